// File: doc/BRIEF.md
# SPI-Controlled UART Register and Interrupt Block

This block is the control plane of a UART that a host reaches over a four-wire serial peripheral bus. Every transaction is one 16-bit frame, sent in SPI mode 0. The host writes on MOSI, and the block samples MOSI on the rising SCLK edge. The block updates MISO on the falling edge, MSB first. The two top bits of each frame select one of four operations: read data, read configuration, write data and write configuration. The remaining bits carry configuration or data. All SPI pins are brought into the system clock domain through two-stage synchronizers.

The block stores the configuration and passes it to the datapath. The configuration holds:
- a 4-bit baud divisor select,
- a FIFO disable bit,
- an IrDA mode bit,
- a 7-bit word length bit,
- a parity enable bit,
- three interrupt masks,
- the request-to-send control bit.

The block also tracks the receive-available flag R, reports the inverted clear-to-send pin, and drives an active-low interrupt. The datapath supplies the receive head word and its flags. In return, the block pulses a pop strobe when a data frame consumes that word. On a write-data frame, it pulses a transmit load strobe carrying the byte and the extra transmit bit.

Top module: `uart_spi_ctl`

## Requirements
- R1: After reset, every configuration bit and the baud select are 0, `rts_pin` is 1, `irq_n` is 1 while no receive source is active, and no strobe is pulsed.
- R2: A write-config frame (bits 15:14 = 11) stores bits 11:0 when the frame completes. The bit layout is: bit 11 FIFO disable, bit 10 IrDA, bit 9 seven-bit length, bit 8 parity enable, bit 7 R mask, bit 6 extra-bit mask, bit 5 error mask, bit 4 RTS, bits 3:0 baud select. These values appear on the configuration outputs. A read-config frame (01) returns the stored value in response bits 11:0.
- R3: Response bit 13 of every frame is the inverse of the synchronized `cts_pin` level.
- R4: `rts_pin` is the inverse of the stored RTS bit.
- R5: `irq_n` is low exactly when at least one masked source is active: R mask with R, extra-bit mask with Pr, or error mask with `rx_err`. Pr is `rx_par` gated by parity enable and `rx_avail`. The output has no latching.
- R6: R follows `rx_avail` outside frames and holds during a frame. A read-data (00) or write-data (10) frame that starts with R = 1 pulses `rx_pop` for one cycle at the 16th falling SCLK edge. R then takes the value of `rx_more`.
- R7: A data frame that starts with R = 0 does not pulse `rx_pop`. A read-config frame never pulses it.
- R8: A write-data frame that starts with `tx_ready` = 1 pulses `tx_load` once. With the pulse:
  - `tx_data` is frame bits 7:0, with bit 7 forced to 0 in seven-bit mode.
  - `tx_par` is frame bit 8 when parity is enabled, else 0.
  
  A write-data frame that starts with `tx_ready` = 0 loads nothing.
- R9: The response word of a data frame is laid out as follows: bit 15 R, bit 14 `tx_ready`, bit 13 CTS status, bit 12 `rx_err`, bit 8 Pr, bits 7:0 receive data, and the other bits 0. The receive data field is 0 when no data is available, and its bit 7 is 0 in seven-bit mode. Config frames return bits 15:13 the same way, with bit 12 = 0.
- R10: A frame in which chip select rises before the 16th falling SCLK edge changes no register and pulses no strobe.
- R11: A read-config frame leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host to block data |
| spi_miso | output | 1 | Block to host data, MSB first |
| cts_pin | input | 1 | Clear-to-send pin level |
| rts_pin | output | 1 | Request-to-send pin level |
| irq_n | output | 1 | Active-low interrupt |
| rx_avail | input | 1 | Receive head word is valid |
| rx_more | input | 1 | At least one more word waits behind the head |
| rx_data | input | 8 | Receive head data |
| rx_par | input | 1 | Extra received bit of the head word |
| rx_err | input | 1 | Receive error flag |
| rx_pop | output | 1 | One-cycle pop of the head word |
| tx_ready | input | 1 | Transmitter can accept a word |
| tx_load | output | 1 | One-cycle transmit load strobe |
| tx_data | output | 8 | Transmit byte |
| tx_par | output | 1 | Extra transmit bit |
| baud_sel | output | 4 | Baud divisor select |
| fifo_dis | output | 1 | Receive FIFO disabled when 1 |
| irda_en | output | 1 | IrDA timing mode |
| len7 | output | 1 | Seven-bit word length |
| par_en | output | 1 | Extra bit enabled |

## Verification
The bench aims at the point where R clears. It checks that R is 1 in the response, that exactly one pop occurs, and that the flag survives the pop when a second word is waiting. A design that cleared R at the start of the frame would report R = 0. A design that popped twice, or ignored `rx_more`, would miscount pops and lose the interrupt. Cut-short frames are sent for both config and data operations, to catch a design that commits on a partial frame. The inverted CTS and RTS pins, seven-bit masking, and parity-gated Pr are each checked against both polarities, so any swapped sense shows as a wrong response bit or a wrong pin level.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BAUD_W     = 4;
  localparam int DATA_W     = 8;

  typedef enum logic [1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } spi_op_e;

  typedef struct packed {
    logic              fifo_dis;
    logic              irda;
    logic              len7;
    logic              par_en;
    logic              rm;
    logic              pm;
    logic              ram;
    logic              rts;
    logic [BAUD_W-1:0] baud;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/uctl_spi_front.sv
module uctl_spi_front
  import uart_ctl_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [NBITS-1:0] load_word,
  input  logic [NBITS-1:0] resp_word,
  output logic             miso,
  output logic             in_frame,
  output logic             frame_start,
  output logic             op_evt,
  output spi_op_e          op_code,
  output logic             frame_done,
  output logic [NBITS-1:0] frame_word
);
  localparam int CW = $clog2(NBITS + 1);

  logic [SYNC:0]    sclk_s, cs_s;
  logic [SYNC-1:0]  mosi_s;
  logic             rise, fall, cs_fall;
  logic [CW-1:0]    rise_cnt, fall_cnt;
  logic [NBITS-1:0] sh_in, sh_out;
  logic             op_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC-1:0], sclk};
      cs_s   <= {cs_s[SYNC-1:0], cs_n};
      mosi_s <= {mosi_s[SYNC-2:0], mosi};
    end
  end

  assign rise     = sclk_s[SYNC-1] & ~sclk_s[SYNC];
  assign fall     = ~sclk_s[SYNC-1] & sclk_s[SYNC];
  assign cs_fall  = ~cs_s[SYNC-1] & cs_s[SYNC];
  assign in_frame = ~cs_s[SYNC-1];
  assign frame_start = cs_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      sh_in      <= '0;
      sh_out     <= '0;
      miso       <= 1'b0;
      op_pend    <= 1'b0;
      op_evt     <= 1'b0;
      op_code    <= OP_RD_DATA;
      frame_done <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_done <= 1'b0;
      op_evt     <= op_pend;
      op_pend    <= 1'b0;
      if (cs_fall) begin
        rise_cnt <= '0;
        fall_cnt <= '0;
        sh_out   <= load_word;
        miso     <= load_word[NBITS-1];
      end else if (in_frame) begin
        if (op_evt) begin
          sh_out <= {resp_word[NBITS-2:0], 1'b0};
        end
        if (rise && rise_cnt < CW'(NBITS)) begin
          sh_in    <= {sh_in[NBITS-2:0], mosi_s[SYNC-1]};
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == CW'(1)) begin
            op_code <= spi_op_e'({sh_in[0], mosi_s[SYNC-1]});
            op_pend <= 1'b1;
          end
        end
        if (fall && rise_cnt != '0 && fall_cnt < CW'(NBITS)) begin
          fall_cnt <= fall_cnt + 1'b1;
          sh_out   <= {sh_out[NBITS-2:0], 1'b0};
          miso     <= sh_out[NBITS-2];
          if (fall_cnt == CW'(NBITS - 1)) begin
            frame_done <= 1'b1;
            frame_word <= sh_in;
          end
        end
      end
    end
  end

  // R10: a completed frame has seen every rising edge
  p_done_full_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> rise_cnt == CW'(NBITS));
endmodule

// File: rtl/uctl_cfg.sv
module uctl_cfg
  import uart_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (we) cfg <= wdata;
  end

  // R11: configuration changes only on a committed write-config frame
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !we |=> cfg == $past(cfg));
endmodule

// File: rtl/uctl_rx_status.sv
module uctl_rx_status (
  input  logic clk,
  input  logic rst,
  input  logic in_frame,
  input  logic pop_req,
  input  logic rx_avail,
  input  logic rx_more,
  input  logic rx_par,
  input  logic rx_err,
  input  logic par_en,
  input  logic rm,
  input  logic pm,
  input  logic ram,
  output logic r_flag,
  output logic pr_bit,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) r_flag <= 1'b0;
    else if (pop_req) r_flag <= rx_more;
    else if (!in_frame) r_flag <= rx_avail;
  end

  assign pr_bit = par_en & rx_par & rx_avail;
  assign irq_n  = ~((rm & r_flag) | (pm & pr_bit) | (ram & rx_err));

  // R6: the flag is frozen inside a frame except at the pop
  p_r_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !pop_req && $past(in_frame)) |=> $stable(r_flag) || !$past(in_frame));
endmodule

// File: rtl/uart_spi_ctl.sv
module uart_spi_ctl
  import uart_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              cts_pin,
  output logic              rts_pin,
  output logic              irq_n,
  input  logic              rx_avail,
  input  logic              rx_more,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              rx_err,
  output logic              rx_pop,
  input  logic              tx_ready,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_par,
  output logic [BAUD_W-1:0] baud_sel,
  output logic              fifo_dis,
  output logic              irda_en,
  output logic              len7,
  output logic              par_en
);
  localparam int PAD_D = FRAME_BITS - 4 - 1 - DATA_W;
  localparam int PAD_C = FRAME_BITS - 3 - CFG_W;

  logic [FRAME_BITS-1:0] load_word, resp_word, frame_word;
  logic    in_frame, frame_start, op_evt, frame_done;
  spi_op_e op_code, done_op;
  cfg_t    cfg;
  logic    cfg_we, pop_req, r_flag, pr_bit;
  logic    r_snap, t_snap;
  logic [1:0] cts_s;
  logic       cts_stat;
  logic [DATA_W-1:0] rd_bits;

  always_ff @(posedge clk) begin
    if (rst) cts_s <= '1;
    else     cts_s <= {cts_s[0], cts_pin};
  end
  assign cts_stat = ~cts_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      r_snap <= 1'b0;
      t_snap <= 1'b0;
    end else if (frame_start) begin
      r_snap <= r_flag;
      t_snap <= tx_ready;
    end
  end

  assign load_word = {r_flag, tx_ready, cts_stat, {(FRAME_BITS-3){1'b0}}};
  assign rd_bits   = rx_avail ? {rx_data[DATA_W-1] & ~cfg.len7, rx_data[DATA_W-2:0]} : '0;

  always_comb begin
    if (op_code == OP_RD_CFG || op_code == OP_WR_CFG)
      resp_word = {r_snap, t_snap, cts_stat, {PAD_C{1'b0}}, cfg};
    else
      resp_word = {r_snap, t_snap, cts_stat, rx_err, {PAD_D{1'b0}}, pr_bit, rd_bits};
  end

  uctl_spi_front u_front (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .load_word(load_word), .resp_word(resp_word), .miso(spi_miso),
    .in_frame(in_frame), .frame_start(frame_start), .op_evt(op_evt),
    .op_code(op_code), .frame_done(frame_done), .frame_word(frame_word)
  );

  assign done_op = spi_op_e'(frame_word[FRAME_BITS-1 -: 2]);
  assign cfg_we  = frame_done && done_op == OP_WR_CFG;
  assign pop_req = frame_done && r_snap &&
                   (done_op == OP_RD_DATA || done_op == OP_WR_DATA);

  uctl_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_t'(frame_word[CFG_W-1:0])), .cfg(cfg)
  );

  uctl_rx_status u_stat (
    .clk(clk), .rst(rst), .in_frame(in_frame), .pop_req(pop_req),
    .rx_avail(rx_avail), .rx_more(rx_more), .rx_par(rx_par), .rx_err(rx_err),
    .par_en(cfg.par_en), .rm(cfg.rm), .pm(cfg.pm), .ram(cfg.ram),
    .r_flag(r_flag), .pr_bit(pr_bit), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pop  <= 1'b0;
      tx_load <= 1'b0;
      tx_data <= '0;
      tx_par  <= 1'b0;
      rts_pin <= 1'b1;
    end else begin
      rx_pop  <= pop_req;
      rts_pin <= ~cfg.rts;
      tx_load <= frame_done && done_op == OP_WR_DATA && t_snap;
      if (frame_done && done_op == OP_WR_DATA && t_snap) begin
        tx_data <= {frame_word[DATA_W-1] & ~cfg.len7, frame_word[DATA_W-2:0]};
        tx_par  <= frame_word[DATA_W] & cfg.par_en;
      end
    end
  end

  assign baud_sel = cfg.baud;
  assign fifo_dis = cfg.fifo_dis;
  assign irda_en  = cfg.irda;
  assign len7     = cfg.len7;
  assign par_en   = cfg.par_en;

  // R6: one pop per frame
  p_pop_single_r6: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);
  // R7: a pop follows only a frame that began with R set
  p_pop_needs_r_r7: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(r_flag));
  // R8: one load per frame
  p_load_single_r8: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);
endmodule

// File: tb/test_uart_spi_ctl.sv
module test_uart_spi_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, rts_pin, irq_n, rx_pop, tx_load, tx_par;
  logic cts_pin = 1'b1;
  logic [7:0] rx_data = 8'h00, tx_data;
  logic rx_par = 1'b0, rx_err = 1'b0, tx_ready = 1'b1;
  logic [3:0] baud_sel;
  logic fifo_dis, irda_en, len7, par_en;
  int fifo_cnt = 0;
  logic set_req = 1'b0;
  int set_val = 0;
  logic rx_avail, rx_more;
  int pass_cnt = 0, fail_cnt = 0, pop_cnt = 0, load_cnt = 0;
  logic [15:0] exp_q[$], got_q[$];
  string tag_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  assign rx_avail = fifo_cnt > 0;
  assign rx_more  = fifo_cnt > 1;

  always @(posedge clk) begin
    if (set_req) fifo_cnt <= set_val;
    else if (rx_pop && fifo_cnt > 0) fifo_cnt <= fifo_cnt - 1;
    if (rx_pop) pop_cnt <= pop_cnt + 1;
    if (tx_load) load_cnt <= load_cnt + 1;
  end

  uart_spi_ctl i_uart_spi_ctl (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .cts_pin(cts_pin), .rts_pin(rts_pin), .irq_n(irq_n),
    .rx_avail(rx_avail), .rx_more(rx_more), .rx_data(rx_data), .rx_par(rx_par),
    .rx_err(rx_err), .rx_pop(rx_pop), .tx_ready(tx_ready), .tx_load(tx_load),
    .tx_data(tx_data), .tx_par(tx_par), .baud_sel(baud_sel), .fifo_dis(fifo_dis),
    .irda_en(irda_en), .len7(len7), .par_en(par_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fifo_set(input int n);
    @(negedge clk); set_val = n; set_req = 1'b1;
    @(negedge clk); set_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits,
                      input logic [15:0] exp, input bit chk, input string tag);
    logic [15:0] got;
    got = '0;
    cs_n = 1'b0; #80;
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i]; #80;
      sclk = 1'b1; got[15-i] = miso; #80;
      sclk = 1'b0;
    end
    #80 cs_n = 1'b1; #160;
    @(negedge clk);
    if (chk) begin
      exp_q.push_back(exp); tag_q.push_back(tag); got_q.push_back(got);
    end
  endtask

  initial begin
    forever begin
      wait (got_q.size() > 0);
      check(tag_q.pop_front(), {16'h0, got_q.pop_front()}, {16'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      fail_cnt++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 baud", baud_sel, 0);
    check("R1 flags", {fifo_dis, irda_en, len7, par_en}, 0);
    check("R1 rts_pin", rts_pin, 1);
    check("R1 irq_n", irq_n, 1);
    check("R1 strobes", {rx_pop, tx_load}, 0);
    xfer(16'h4000, 16, 16'h4000, 1, "R1 R11 reset readback");

    xfer(16'hCBBA, 16, 16'h4000, 1, "R2 write cfg response");
    check("R2 baud", baud_sel, 4'hA);
    check("R2 flags", {fifo_dis, irda_en, len7, par_en}, 4'b1011);
    check("R4 rts low", rts_pin, 0);
    cts_pin = 1'b0;
    repeat (4) @(negedge clk);
    xfer(16'h4000, 16, 16'h6BBA, 1, "R2 R3 read cfg");

    xfer(16'hC000, 8, 16'h0, 0, "");
    xfer(16'h4000, 16, 16'h6BBA, 1, "R10 aborted cfg write");

    rx_err = 1'b1; repeat (2) @(negedge clk);
    check("R5 err source", irq_n, 0);
    rx_err = 1'b0; repeat (2) @(negedge clk);
    check("R5 err cleared", irq_n, 1);

    rx_data = 8'hC3; rx_par = 1'b1;
    fifo_set(1);
    check("R5 R source", irq_n, 0);
    xfer(16'h0000, 8, 16'h0, 0, "");
    check("R10 aborted read no pop", pop_cnt, 0);
    xfer(16'h0000, 16, 16'hE143, 1, "R9 read data len7 parity");
    check("R6 pop once", pop_cnt, 1);
    check("R6 R cleared irq", irq_n, 1);
    xfer(16'h0000, 16, 16'h6000, 1, "R7 R9 empty read");
    check("R7 no pop", pop_cnt, 1);

    xfer(16'h81FF, 16, 16'h6000, 1, "R8 write data response");
    check("R8 load count", load_cnt, 1);
    check("R8 len7 mask", tx_data, 8'h7F);
    check("R8 parity bit", tx_par, 1);

    xfer(16'hC083, 16, 16'h6BBA, 1, "R2 rewrite cfg");
    check("R4 rts high", rts_pin, 1);
    check("R2 baud 3", baud_sel, 4'h3);
    xfer(16'h819C, 16, 16'h6000, 1, "R8 write data 8 bit");
    check("R8 full byte", tx_data, 8'h9C);
    check("R8 parity masked", tx_par, 0);

    tx_ready = 1'b0; repeat (2) @(negedge clk);
    xfer(16'h8011, 16, 16'h2000, 1, "R8 not ready response");
    check("R8 no load", load_cnt, 2);
    tx_ready = 1'b1;

    rx_data = 8'hA5;
    fifo_set(2);
    xfer(16'h0000, 16, 16'hE0A5, 1, "R9 read data 8 bit");
    check("R6 pop with more", pop_cnt, 2);
    check("R6 R kept irq", irq_n, 0);
    xfer(16'h4000, 16, 16'hE083, 1, "R11 read cfg with data");
    check("R7 cfg read no pop", pop_cnt, 2);
    xfer(16'h0000, 16, 16'hE0A5, 1, "R6 second word");
    check("R6 pop last", pop_cnt, 3);
    check("R6 R finally clear", irq_n, 1);

    xfer(16'hC140, 16, 16'h6083, 1, "R2 pm cfg");
    rx_par = 1'b1;
    fifo_set(1);
    check("R5 Pr source", irq_n, 0);
    rx_par = 1'b0; repeat (2) @(negedge clk);
    check("R5 Pr cleared", irq_n, 1);
    rx_err = 1'b1; repeat (2) @(negedge clk);
    check("R5 err masked", irq_n, 1);
    rx_err = 1'b0;
    cts_pin = 1'b1; repeat (4) @(negedge clk);
    xfer(16'h4000, 16, 16'hC140, 1, "R3 cts high");

    wait (got_q.size() == 0);
    #20;
    finished = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule